// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the power states of a small microcontroller core. It runs from an always-on reference clock and moves the core between four states: RUN, STANDBY (the CPU clock is gated while the oscillator, timers and interrupt logic keep running), SLEEP (the oscillator is off and only the reset pin is watched) and a wake-wait state. In the wake-wait state the oscillator is restarting and the core is held in reset.

The CPU enters STANDBY by pulsing a halt strobe. Any interrupt whose enable bit is set returns it to RUN. SLEEP takes two register writes: software first sets a mask bit, then writes the sleep bit. The only way out of SLEEP is an external reset pulse that stays high long enough. That reset clears the sleep flag and keeps the mask bit, so after a restart software can tell a wake from SLEEP apart from a power-up.

All outputs are registered. The reset-pulse width and the oscillator start-up time are counted in reference-clock cycles and set by parameters.

Top module: `lpm_ctrl`

## Requirements
- R1: While `por` is high, `core_rst` and `rst_strobe` are 1, `cpu_clk_en` and `periph_clk_en` are 0, and `slmask_flag` and `sleep_flag` clear to 0. One cycle after `por` falls, the outputs show RUN: `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1 and `core_rst` is 0.
- R2: A `halt_req` in RUN moves the block to STANDBY on the next clock edge. In STANDBY `cpu_clk_en` is 0, while `periph_clk_en`, `osc_en` and `io_hold` are 1.
- R3: STANDBY returns to RUN, without a reset, as soon as some bit i has both `irq_req[i]` and `irq_en[i]` high. A request whose enable bit is clear has no effect.
- R4: In RUN, a strobe on `mask_wr` loads `mask_wdata` into the mask bit, which `slmask_flag` shows. Register writes are ignored in any other state.
- R5: In RUN, a strobe on `sleep_wr` with `sleep_wdata`=1 enters SLEEP only if `slmask_flag` was already 1 before that cycle. A mask write in the same cycle does not count. In SLEEP `sleep_flag`=1 and `osc_en`, `cpu_clk_en` and `periph_clk_en` are all 0.
- R6: In SLEEP, interrupts, `halt_req` and register writes have no effect.
- R7: `ext_rst` is accepted only after its synchronised value has been high for `PULSE_MIN` consecutive reference-clock cycles. A pulse of `PULSE_MIN`-1 cycles is ignored.
- R8: An accepted reset in SLEEP raises `osc_en`, `core_rst` and `rst_strobe` together on the same edge. If the pin has already been released, the block returns to RUN exactly `STARTUP_CYCLES` cycles later.
- R9: A wake from SLEEP clears `sleep_flag` and leaves `slmask_flag` at 1.
- R10: An accepted reset in RUN or STANDBY holds `core_rst` high while the pin stays qualified, with no start-up wait. `core_rst` drops `SYNC_STAGES`+1 cycles after the pin falls, the block returns to RUN, and the mask bit is kept.
- R11: In SLEEP, `io_hiz`=1 and `io_hold`=0 when `SLEEP_IO_TRISTATE`=1. Otherwise `io_hold`=1 and `io_hiz`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| halt_req | input | 1 | Halt strobe from the CPU |
| irq_req | input | IRQ_W | Pending interrupt requests |
| irq_en | input | IRQ_W | Interrupt enable bits |
| mask_wr | input | 1 | Write strobe for the sleep mask bit |
| mask_wdata | input | 1 | Value written to the mask bit |
| sleep_wr | input | 1 | Write strobe for the sleep bit |
| sleep_wdata | input | 1 | Value written to the sleep bit |
| ext_rst | input | 1 | External reset pin, active high, asynchronous |
| cpu_clk_en | output | 1 | Instruction clock enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| core_rst | output | 1 | Internal reset to the core |
| rst_strobe | output | 1 | Reset/strobe output pin, high during reset |
| io_hold | output | 1 | Hold I/O pin states |
| io_hiz | output | 1 | Tristate I/O pins |
| sleep_flag | output | 1 | Sleep bit readback |
| slmask_flag | output | 1 | Mask bit readback |

## Verification
The bound checker evaluates several properties on every cycle. It checks that the CPU clock is never enabled during reset or STANDBY, that SLEEP never runs with the oscillator or the clocks on, and that SLEEP is entered only with the mask already set. It also checks that every exit from SLEEP happens under reset with the mask kept, that the CPU clock starts only once the oscillator is already running, and that the strobe pin follows the internal reset. Some behaviours depend on a number of cycles or on a pattern of events, and only the bench scenarios exercise them. These are rejection of a pulse one cycle too short, acceptance at exactly the threshold, the exact length of the start-up interval, the release latency of a reset taken in RUN, the ignored interrupts whose enable is clear, and the mask value after a wake compared with after a power-on.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STANDBY = 2'd1,
    ST_SLEEP   = 2'd2,
    ST_WAKE    = 2'd3
  } lpm_state_e;

  typedef struct packed {
    logic cpu_clk_en;
    logic periph_clk_en;
    logic osc_en;
    logic core_rst;
    logic io_hold;
    logic io_hiz;
  } lpm_outs_t;

  // Output levels for a given (next) state; rst_hold is a qualified pin reset
  function automatic lpm_outs_t lpm_decode(lpm_state_e st, logic rst_hold, logic hiz_mode);
    lpm_outs_t o;
    o = '0;
    case (st)
      ST_RUN: begin
        o.cpu_clk_en    = !rst_hold;
        o.periph_clk_en = !rst_hold;
        o.osc_en        = 1'b1;
        o.core_rst      = rst_hold;
      end
      ST_STANDBY: begin
        o.periph_clk_en = 1'b1;
        o.osc_en        = 1'b1;
        o.io_hold       = 1'b1;
        o.core_rst      = rst_hold;
      end
      ST_SLEEP: begin
        o.io_hold = !hiz_mode;
        o.io_hiz  = hiz_mode;
      end
      default: begin
        o.osc_en   = 1'b1;
        o.core_rst = 1'b1;
      end
    endcase
    return o;
  endfunction

  localparam lpm_outs_t LPM_OUTS_POR = '{cpu_clk_en: 1'b0, periph_clk_en: 1'b0,
                                         osc_en: 1'b1, core_rst: 1'b1,
                                         io_hold: 1'b0, io_hiz: 1'b0};

endpackage

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_MIN   = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic qual_o
);
  localparam int CW = $clog2(PULSE_MIN + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(PULSE_MIN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          width_q;
  logic                   pin_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  // Saturating width counter: restarts whenever the synchronised pin is low
  always_ff @(posedge clk) begin
    if (rst || !pin_s)          width_q <= '0;
    else if (width_q != CNT_MAX) width_q <= width_q + 1'b1;
  end

  assign qual_o = (width_q == CNT_MAX);

endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int STARTUP_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(STARTUP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i)  cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter bit SLEEP_IO_TRISTATE = 1'b0
) (
  input  logic       clk,
  input  logic       por,
  input  logic       halt_req,
  input  logic       irq_hit,
  input  logic       mask_wr,
  input  logic       mask_wdata,
  input  logic       sleep_wr,
  input  logic       sleep_wdata,
  input  logic       rst_qual,
  input  logic       wake_done,
  output lpm_state_e state_o,
  output logic       sleep_o,
  output logic       mask_o,
  output lpm_outs_t  outs_o
);
  lpm_state_e state_q, state_n;
  logic       sleep_q, sleep_n;
  logic       mask_q,  mask_n;
  lpm_outs_t  outs_q;

  always_comb begin
    state_n = state_q;
    sleep_n = sleep_q;
    mask_n  = mask_q;
    if (rst_qual) begin
      // Pin reset: clears sleep, keeps mask; oscillator restart only if it was off
      sleep_n = 1'b0;
      state_n = (state_q == ST_SLEEP || state_q == ST_WAKE) ? ST_WAKE : ST_RUN;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (mask_wr) mask_n = mask_wdata;
          if (sleep_wr && sleep_wdata && mask_q) begin
            state_n = ST_SLEEP;
            sleep_n = 1'b1;
          end else if (halt_req) begin
            state_n = ST_STANDBY;
          end
        end
        ST_STANDBY: if (irq_hit)   state_n = ST_RUN;
        ST_WAKE:    if (wake_done) state_n = ST_RUN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      state_q <= ST_RUN;
      sleep_q <= 1'b0;
      mask_q  <= 1'b0;
      outs_q  <= LPM_OUTS_POR;
    end else begin
      state_q <= state_n;
      sleep_q <= sleep_n;
      mask_q  <= mask_n;
      outs_q  <= lpm_decode(state_n, rst_qual, SLEEP_IO_TRISTATE);
    end
  end

  assign state_o = state_q;
  assign sleep_o = sleep_q;
  assign mask_o  = mask_q;
  assign outs_o  = outs_q;

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int IRQ_W             = 4,
  parameter int SYNC_STAGES       = 2,
  parameter int PULSE_MIN         = 500,
  parameter int STARTUP_CYCLES    = 4096,
  parameter bit SLEEP_IO_TRISTATE = 1'b0
) (
  input  logic             clk,
  input  logic             por,
  input  logic             halt_req,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic             mask_wr,
  input  logic             mask_wdata,
  input  logic             sleep_wr,
  input  logic             sleep_wdata,
  input  logic             ext_rst,
  output logic             cpu_clk_en,
  output logic             osc_en,
  output logic             periph_clk_en,
  output logic             core_rst,
  output logic             rst_strobe,
  output logic             io_hold,
  output logic             io_hiz,
  output logic             sleep_flag,
  output logic             slmask_flag
);
  lpm_state_e state;
  lpm_outs_t  outs;
  logic       rst_qual;
  logic       wake_done;
  logic       irq_hit;

  assign irq_hit = |(irq_req & irq_en);

  lpm_rst_qual #(
    .SYNC_STAGES(SYNC_STAGES),
    .PULSE_MIN  (PULSE_MIN)
  ) u_qual (
    .clk   (clk),
    .rst   (por),
    .pin_in(ext_rst),
    .qual_o(rst_qual)
  );

  lpm_wake_timer #(
    .STARTUP_CYCLES(STARTUP_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst   (por),
    .run_i (state == ST_WAKE),
    .done_o(wake_done)
  );

  lpm_fsm #(
    .SLEEP_IO_TRISTATE(SLEEP_IO_TRISTATE)
  ) u_fsm (
    .clk        (clk),
    .por        (por),
    .halt_req   (halt_req),
    .irq_hit    (irq_hit),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .sleep_wr   (sleep_wr),
    .sleep_wdata(sleep_wdata),
    .rst_qual   (rst_qual),
    .wake_done  (wake_done),
    .state_o    (state),
    .sleep_o    (sleep_flag),
    .mask_o     (slmask_flag),
    .outs_o     (outs)
  );

  assign cpu_clk_en    = outs.cpu_clk_en;
  assign periph_clk_en = outs.periph_clk_en;
  assign osc_en        = outs.osc_en;
  assign core_rst      = outs.core_rst;
  assign rst_strobe    = outs.core_rst;
  assign io_hold       = outs.io_hold;
  assign io_hiz        = outs.io_hiz;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic clk,
  input logic por,
  input logic cpu_clk_en,
  input logic osc_en,
  input logic periph_clk_en,
  input logic core_rst,
  input logic rst_strobe,
  input logic io_hold,
  input logic sleep_flag,
  input logic slmask_flag
);
  assert_cpu_off_in_reset_R1: assert property (@(posedge clk) disable iff (por)
    core_rst |-> !cpu_clk_en);

  assert_standby_cpu_gated_R2: assert property (@(posedge clk) disable iff (por)
    (io_hold && osc_en) |-> (!cpu_clk_en && periph_clk_en));

  assert_sleep_needs_mask_R5: assert property (@(posedge clk) disable iff (por)
    $rose(sleep_flag) |-> (slmask_flag && $past(slmask_flag)));

  assert_sleep_clocks_off_R5: assert property (@(posedge clk) disable iff (por)
    sleep_flag |-> (!osc_en && !cpu_clk_en && !periph_clk_en));

  assert_wake_under_reset_R8: assert property (@(posedge clk) disable iff (por)
    $fell(sleep_flag) |-> (core_rst && osc_en));

  assert_cpu_after_osc_R8: assert property (@(posedge clk) disable iff (por)
    $rose(cpu_clk_en) |-> $past(osc_en));

  assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (por)
    rst_strobe == core_rst);

  assert_mask_kept_on_wake_R9: assert property (@(posedge clk) disable iff (por)
    $fell(sleep_flag) |-> slmask_flag);

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk          (clk),
  .por          (por),
  .cpu_clk_en   (cpu_clk_en),
  .osc_en       (osc_en),
  .periph_clk_en(periph_clk_en),
  .core_rst     (core_rst),
  .rst_strobe   (rst_strobe),
  .io_hold      (io_hold),
  .sleep_flag   (sleep_flag),
  .slmask_flag  (slmask_flag)
);

// File: tb/lpm_ctrl_test.sv
`timescale 1ns/1ps
module lpm_ctrl_test;
  localparam int IRQ_W   = 4;
  localparam int SYNC    = 2;
  localparam int PMIN    = 8;
  localparam int STARTUP = 24;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic halt_req = 1'b0;
  logic [IRQ_W-1:0] irq_req = '0, irq_en = '0;
  logic mask_wr = 1'b0, mask_wdata = 1'b0, sleep_wr = 1'b0, sleep_wdata = 1'b0;
  logic ext_rst = 1'b0;
  logic cpu_clk_en, osc_en, periph_clk_en, core_rst, rst_strobe, io_hold, io_hiz;
  logic sleep_flag, slmask_flag;
  logic h_cpu, h_osc, h_per, h_rst, h_strb, h_hold, h_hiz, h_sleep, h_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lpm_ctrl #(.IRQ_W(IRQ_W), .SYNC_STAGES(SYNC), .PULSE_MIN(PMIN),
             .STARTUP_CYCLES(STARTUP), .SLEEP_IO_TRISTATE(1'b0)) uut (
    .clk(clk), .por(por), .halt_req(halt_req), .irq_req(irq_req), .irq_en(irq_en),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .sleep_wr(sleep_wr),
    .sleep_wdata(sleep_wdata), .ext_rst(ext_rst), .cpu_clk_en(cpu_clk_en),
    .osc_en(osc_en), .periph_clk_en(periph_clk_en), .core_rst(core_rst),
    .rst_strobe(rst_strobe), .io_hold(io_hold), .io_hiz(io_hiz),
    .sleep_flag(sleep_flag), .slmask_flag(slmask_flag));

  // Tristate variant driven by the same stimulus (R11)
  lpm_ctrl #(.IRQ_W(IRQ_W), .SYNC_STAGES(SYNC), .PULSE_MIN(PMIN),
             .STARTUP_CYCLES(STARTUP), .SLEEP_IO_TRISTATE(1'b1)) uut_hiz (
    .clk(clk), .por(por), .halt_req(halt_req), .irq_req(irq_req), .irq_en(irq_en),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .sleep_wr(sleep_wr),
    .sleep_wdata(sleep_wdata), .ext_rst(ext_rst), .cpu_clk_en(h_cpu),
    .osc_en(h_osc), .periph_clk_en(h_per), .core_rst(h_rst),
    .rst_strobe(h_strb), .io_hold(h_hold), .io_hiz(h_hiz),
    .sleep_flag(h_sleep), .slmask_flag(h_mask));

  // {halt, irq_req, irq_en, mask_wr, mask_wdata, sleep_wr, sleep_wdata,
  //  expected {cpu_clk_en, periph_clk_en, osc_en, io_hold, sleep_flag, slmask_flag}}
  localparam int NV = 11;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 4'h0, 4'h0, 4'b0000, 6'b111000},  // idle RUN
    {1'b0, 4'h0, 4'h0, 4'b0011, 6'b111000},  // R5 sleep write, mask 0: ignored
    {1'b0, 4'h0, 4'h0, 4'b1111, 6'b111001},  // R4 mask set; R5 same-cycle sleep ignored
    {1'b1, 4'h0, 4'h0, 4'b0000, 6'b011101},  // R2 halt -> STANDBY
    {1'b0, 4'h1, 4'h2, 4'b0000, 6'b011101},  // R3 irq without enable: stay
    {1'b0, 4'h0, 4'h0, 4'b1011, 6'b011101},  // R4 writes ignored in STANDBY
    {1'b0, 4'h4, 4'h4, 4'b0000, 6'b111001},  // R3 enabled irq -> RUN
    {1'b0, 4'h0, 4'h0, 4'b1000, 6'b111000},  // R4 mask clear
    {1'b0, 4'h0, 4'h0, 4'b1100, 6'b111001},  // R4 mask set
    {1'b0, 4'h0, 4'h0, 4'b0011, 6'b000111},  // R5 SLEEP entry
    {1'b1, 4'hF, 4'hF, 4'b1000, 6'b000111}   // R6 irq/halt/write ignored in SLEEP
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pin_pulse(input int n);
    @(negedge clk) ext_rst = 1'b1;
    repeat (n) @(negedge clk);
    ext_rst = 1'b0;
  endtask

  function automatic logic [5:0] snap();
    return {cpu_clk_en, periph_clk_en, osc_en, io_hold, sleep_flag, slmask_flag};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    int cnt;
    logic seen;
    repeat (4) @(negedge clk);
    // R1 during power-on reset
    check("R1 core_rst/strobe/cpu/periph/mask in por",
          {core_rst, rst_strobe, cpu_clk_en, periph_clk_en, slmask_flag}, 5'b11000);
    por = 1'b0;
    @(negedge clk);
    check("R1 RUN after por", {cpu_clk_en, periph_clk_en, osc_en, core_rst}, 4'b1110);

    for (int i = 0; i < NV; i++) begin
      {halt_req, irq_req, irq_en, mask_wr, mask_wdata, sleep_wr, sleep_wdata} = VEC[i][18:6];
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), snap(), VEC[i][5:0]);
    end
    {halt_req, irq_req, irq_en, mask_wr, mask_wdata, sleep_wr, sleep_wdata} = '0;

    // R11 I/O policy in SLEEP
    check("R11 hold variant", {io_hold, io_hiz}, 2'b10);
    check("R11 tristate variant", {h_hold, h_hiz, h_sleep}, 3'b011);

    // R7 short pulse in SLEEP is rejected
    pin_pulse(PMIN - 1);
    seen = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (core_rst || osc_en) seen = 1'b1;
    end
    check("R7 short pulse ignored", {seen, sleep_flag}, 2'b01);

    // R7/R8 pulse of exactly PMIN wakes; start-up interval counted
    pin_pulse(PMIN);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (osc_en && core_rst && rst_strobe) cnt++;
      if (cnt > 0 && !core_rst) break;
    end
    check("R8 start-up cycles", cnt, STARTUP);
    check("R8 RUN after wake", {cpu_clk_en, periph_clk_en, osc_en}, 3'b111);
    check("R9 sleep cleared, mask kept", {sleep_flag, slmask_flag}, 2'b01);

    // R7 short pulse in RUN causes no reset
    pin_pulse(PMIN - 1);
    seen = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (core_rst) seen = 1'b1;
    end
    check("R7 short pulse in RUN", seen, 1'b0);

    // R10 qualified reset in RUN: no start-up wait
    pin_pulse(PMIN + 3);
    check("R10 reset asserted in RUN", {core_rst, osc_en, cpu_clk_en}, 3'b110);
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!core_rst) break;
      cnt++;
    end
    check("R10 release latency RUN", cnt, SYNC + 1);
    check("R10 RUN, mask kept", {cpu_clk_en, slmask_flag, sleep_flag}, 3'b110);

    // R10 qualified reset from STANDBY
    @(negedge clk) halt_req = 1'b1;
    @(negedge clk) halt_req = 1'b0;
    check("R2 STANDBY again", {cpu_clk_en, io_hold}, 2'b01);
    pin_pulse(PMIN + 3);
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!core_rst) break;
      cnt++;
    end
    check("R10 release latency STANDBY", cnt, SYNC + 1);
    check("R10 back to RUN", {cpu_clk_en, io_hold, slmask_flag}, 3'b101);

    // R1 power-on clears mask, unlike a wake
    @(negedge clk) por = 1'b1;
    @(negedge clk);
    check("R1 por clears mask", {slmask_flag, sleep_flag, core_rst}, 3'b001);
    por = 1'b0;
    @(negedge clk);
    check("R1 RUN after second por", {cpu_clk_en, core_rst, slmask_flag}, 3'b100);

    finish_run();
  end
endmodule